// File: doc/BRIEF.md
# CPU Bus Takeover Controller

This block hands the system bus of a classic two-phase 8-bit microprocessor to a DMA master and gives it back. A DMA master raises a request. The controller first stops the processor. It then isolates the processor from the shared bus through the CPU-side transceiver enables, and only after that grants the bus. When the master withdraws its request, the controller undoes these steps in the opposite order: grant first, then the transceivers, then the processor.

Two kinds of processor core are supported, and the choice is sampled when each takeover begins.

- **Dynamic core.** The ready line is negated. That line stalls only read cycles, so the controller waits a fixed drain period before it touches the bus. This lets any run of pending writes finish.
- **Static core.** The processor clock is frozen in its low phase, and the freeze is applied only at the point where a high phase ends. The bus is isolated after a short settle period.

A build parameter can forbid clock freezing altogether, for systems whose cores have a minimum clock rate.

Top module: `dma_bus_takeover`

## Requirements
- R1: After reset the state code is 0 (idle), `cpu_rdy`=1, `xcvr_en`=1, `dma_gnt`=0 and `cpu_clk_run`=1.
- R2: `dma_req` passes through a two-stage synchroniser. A request set up before rising edge 1 makes the state code 1 (stall) after rising edge 3.
- R3: In dynamic mode `cpu_rdy` goes to 0 on entry to stall. `xcvr_en` falls exactly 6 cycles after `cpu_rdy` falls: 1 stall cycle plus 5 wait cycles (state code 2).
- R4: `dma_gnt` is 1 only while `xcvr_en` is 0. It rises one cycle after the grant state (code 3) is entered, and that state is where `xcvr_en` falls.
- R5: In static mode `cpu_rdy` stays 1. Stall lasts until `cpu_phi2` is high. The clock then stops with `cpu_phi2` low, and `cpu_phi2` stays low for as long as `cpu_clk_run` is 0.
- R6: In static mode `xcvr_en` falls 1 cycle after `cpu_clk_run` falls.
- R7: On release (state code 4) `dma_gnt` falls first. `xcvr_en` returns to 1 one cycle later, and `cpu_rdy` or `cpu_clk_run` returns to 1 one cycle after that, when the state code is back to 0.
- R8: If the request is withdrawn before the grant, the sequence still runs through the grant state for one cycle without asserting `dma_gnt`, and then releases normally.
- R9: A request raised during release is ignored until idle is reached. A new takeover then starts one cycle after idle.
- R10: The core mode is captured when a takeover starts. Changes on `static_sel` during a takeover have no effect on that takeover.
- R11: State codes: 0 idle, 1 stall, 2 wait, 3 grant, 4 release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_req | input | 1 | Asynchronous DMA bus request |
| static_sel | input | 1 | 1 selects clock freezing (static core), 0 selects ready stalling |
| dma_gnt | output | 1 | Bus granted to the DMA master |
| cpu_rdy | output | 1 | Processor ready line, active high |
| cpu_phi2 | output | 1 | Processor phase clock, high during phase 2 |
| cpu_clk_run | output | 1 | 1 while the processor clock is allowed to toggle |
| xcvr_en | output | 1 | 1 connects the CPU-side bus transceivers |
| tko_state | output | 3 | Current state code |

## Verification
Two functions of this block can fall in the same cycle.

- **Release completion against a new request.** A request that reappears while the release is still in progress lands in the same cycle as the release finishing. The bench provokes this by dropping the synchronised request for a single cycle during a grant. The only correct outcome is a full release, then one idle cycle, then a fresh stall.
- **Withdrawal against isolation.** A request withdrawn during the write drain meets the transceiver isolation in the same cycle. Together with a mode change at that moment, the bench checks that the grant stays low and the sequence stays in ready-stall mode.

A scoreboard judges every output change by its value and by how many cycles the previous value lasted.

// File: rtl/dma_tko_pkg.sv
package dma_tko_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_STALL = 3'd1,
      ST_WAIT  = 3'd2,
      ST_GRANT = 3'd3,
      ST_REL   = 3'd4
   } tko_state_e;
endpackage

// File: rtl/tko_req_sync.sv
module tko_req_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tko_req_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/tko_phase_gen.sv
module tko_phase_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic phi2
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   phi2 <= 1'b0;
      else if (run) phi2 <= ~phi2;
   end

   // R5
   low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !phi2);
endmodule

// File: rtl/tko_fsm.sv
module tko_fsm
   import dma_tko_pkg::*;
#(
   parameter int unsigned DRAIN        = 6,
   parameter int unsigned SETTLE       = 1,
   parameter bit          ALLOW_STATIC = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_s,
   input  logic       static_sel,
   input  logic       phi2,
   output tko_state_e state,
   output logic       rdy,
   output logic       run,
   output logic       xcvr_en,
   output logic       gnt
);
   localparam int unsigned MAXC  = (DRAIN > SETTLE) ? DRAIN : SETTLE;
   localparam int unsigned CNT_W = $clog2(MAXC + 1);

   logic             eff_static;
   logic             mode_q;
   logic             gnt_q;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] wait_last;

   generate
      if (DRAIN < 2) begin : g_bad_drain
         $error("tko_fsm: DRAIN must be at least 2");
      end
      if (SETTLE < 1) begin : g_bad_settle
         $error("tko_fsm: SETTLE must be at least 1");
      end
      if (ALLOW_STATIC) begin : g_mode_sel
         assign eff_static = static_sel;
      end else begin : g_mode_dyn
         assign eff_static = 1'b0;
      end
   endgenerate

   assign wait_last = mode_q ? CNT_W'(SETTLE - 1) : CNT_W'(DRAIN - 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         mode_q <= 1'b0;
         cnt    <= '0;
         gnt_q  <= 1'b0;
      end else begin
         gnt_q <= (state == ST_GRANT);
         unique case (state)
            ST_IDLE: if (req_s) begin
               state  <= ST_STALL;
               mode_q <= eff_static;
            end
            ST_STALL: if (!mode_q || phi2) begin
               state <= ST_WAIT;
               cnt   <= '0;
            end
            ST_WAIT: if (cnt == wait_last) state <= ST_GRANT;
                     else                  cnt   <= cnt + 1'b1;
            ST_GRANT: if (!req_s) begin
               state <= ST_REL;
               cnt   <= '0;
            end
            ST_REL: if (cnt == CNT_W'(1)) state <= ST_IDLE;
                    else                  cnt   <= cnt + 1'b1;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign rdy     = !((state != ST_IDLE) && !mode_q);
   assign run     = !(mode_q && (state == ST_WAIT || state == ST_GRANT || state == ST_REL));
   assign xcvr_en = !((state == ST_GRANT) || (state == ST_REL && cnt == '0));
   assign gnt     = (state == ST_GRANT) && gnt_q;

   // cycles with ready negated, for the drain-length check
   logic [CNT_W-1:0] low_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     low_cnt <= '0;
      else if (state == ST_IDLE)      low_cnt <= '0;
      else if (low_cnt != CNT_W'(MAXC)) low_cnt <= low_cnt + 1'b1;
   end

   // R4
   gnt_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt |-> !xcvr_en);
   // R4
   gnt_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt) |-> $past(!xcvr_en));
   // R7
   rel_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gnt) |-> !xcvr_en);
   // R7
   reen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xcvr_en) |-> (!rdy || !run));
   // R3
   drain_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(xcvr_en) && !mode_q) |-> (low_cnt == CNT_W'(DRAIN)));
endmodule

// File: rtl/dma_bus_takeover.sv
module dma_bus_takeover
   import dma_tko_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned DRAIN        = 6,
   parameter int unsigned SETTLE       = 1,
   parameter bit          ALLOW_STATIC = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dma_req,
   input  logic       static_sel,
   output logic       dma_gnt,
   output logic       cpu_rdy,
   output logic       cpu_phi2,
   output logic       cpu_clk_run,
   output logic       xcvr_en,
   output logic [2:0] tko_state
);
   logic       req_s;
   tko_state_e st;

   tko_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(dma_req), .q(req_s)
   );

   tko_fsm #(.DRAIN(DRAIN), .SETTLE(SETTLE), .ALLOW_STATIC(ALLOW_STATIC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .req_s(req_s), .static_sel(static_sel),
      .phi2(cpu_phi2), .state(st), .rdy(cpu_rdy), .run(cpu_clk_run),
      .xcvr_en(xcvr_en), .gnt(dma_gnt)
   );

   tko_phase_gen u_phase (
      .clk(clk), .rst_n(rst_n), .run(cpu_clk_run), .phi2(cpu_phi2)
   );

   assign tko_state = st;
endmodule

// File: tb/dma_bus_takeover_tb.sv
module dma_bus_takeover_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dma_req = 1'b0;
   logic static_sel = 1'b0;
   logic dma_gnt, cpu_rdy, cpu_phi2, cpu_clk_run, xcvr_en;
   logic [2:0] tko_state;

   int n_chk = 0;
   int n_bad = 0;
   int dwell_cnt = 0;
   bit done = 1'b0;

   typedef struct {
      logic [6:0] vec;
      int         dwell;
      string      tag;
   } exp_t;
   exp_t q[$];

   always #4 clk = ~clk;

   dma_bus_takeover u_dut (
      .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .static_sel(static_sel),
      .dma_gnt(dma_gnt), .cpu_rdy(cpu_rdy), .cpu_phi2(cpu_phi2),
      .cpu_clk_run(cpu_clk_run), .xcvr_en(xcvr_en), .tko_state(tko_state)
   );

   // vec = {state, rdy, xcvr_en, gnt, run}
   function automatic logic [6:0] mk(input logic [2:0] s, input logic r,
                                     input logic x, input logic g, input logic c);
      return {s, r, x, g, c};
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic push(input logic [6:0] v, input int d, input string tag);
      exp_t e;
      e.vec = v; e.dwell = d; e.tag = tag;
      q.push_back(e);
   endtask

   // monitor: judges every output change against the scoreboard
   logic [6:0] last_vec = 7'd0;
   bit mon_on = 1'b0;
   always @(posedge clk) begin
      #3;
      if (mon_on) begin
         logic [6:0] cur;
         cur = {tko_state, cpu_rdy, xcvr_en, dma_gnt, cpu_clk_run};
         dwell_cnt++;
         // R5: frozen clock always rests low
         if (!cpu_clk_run) check("R5 phi2 low while frozen", int'(cpu_phi2), 0);
         if (cur != last_vec) begin
            if (q.size() == 0) begin
               check("R11 unexpected change", int'(cur), int'(last_vec));
            end else begin
               exp_t e;
               e = q.pop_front();
               check(e.tag, int'(cur), int'(e.vec));
               if (e.dwell >= 0) check({e.tag, " dwell"}, dwell_cnt, e.dwell);
            end
            last_vec = cur;
            dwell_cnt = 0;
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic raise_req();
      @(negedge clk);
      dma_req = 1'b1;
      dwell_cnt = 0;
   endtask

   // dynamic-mode takeover expectations (R2, R3, R4)
   task automatic exp_dyn_take(input int first_dwell);
      push(mk(3'd1, 0, 1, 0, 1), first_dwell, "R2 R3 stall");
      push(mk(3'd2, 0, 1, 0, 1), 1, "R3 wait");
      push(mk(3'd3, 0, 0, 0, 1), 5, "R3 isolate");
      push(mk(3'd3, 0, 0, 1, 1), 1, "R4 grant");
   endtask

   task automatic exp_dyn_rel();
      push(mk(3'd4, 0, 0, 0, 1), -1, "R7 gnt drop");
      push(mk(3'd4, 0, 1, 0, 1), 1, "R7 xcvr back");
      push(mk(3'd0, 1, 1, 0, 1), 1, "R7 rdy back");
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      // R1 reset state
      check("R1 reset vector", int'({tko_state, cpu_rdy, xcvr_en, dma_gnt, cpu_clk_run}),
            int'(mk(3'd0, 1, 1, 0, 1)));
      last_vec = mk(3'd0, 1, 1, 0, 1);
      mon_on = 1'b1;
      cyc(3);

      // dynamic takeover and release
      exp_dyn_take(3);
      raise_req();
      cyc(20);
      exp_dyn_rel();
      dma_req = 1'b0;
      cyc(10);

      // static takeover, twice with different phase alignment (R5, R6)
      for (int k = 0; k < 2; k++) begin
         static_sel = 1'b1;
         cyc(k);
         push(mk(3'd1, 1, 1, 0, 1), 3, "R2 R5 stall static");
         push(mk(3'd2, 1, 1, 0, 0), -1, "R5 clock frozen");
         push(mk(3'd3, 1, 0, 0, 0), 1, "R6 isolate static");
         push(mk(3'd3, 1, 0, 1, 0), 1, "R4 grant static");
         raise_req();
         cyc(20);
         push(mk(3'd4, 1, 0, 0, 0), -1, "R7 gnt drop static");
         push(mk(3'd4, 1, 1, 0, 0), 1, "R7 xcvr back static");
         push(mk(3'd0, 1, 1, 0, 1), 1, "R7 clock back static");
         dma_req = 1'b0;
         cyc(10);
      end

      // R8 withdraw during drain, R10 mode flip mid-sequence
      static_sel = 1'b0;
      push(mk(3'd1, 0, 1, 0, 1), 3, "R8 stall");
      push(mk(3'd2, 0, 1, 0, 1), 1, "R8 wait");
      push(mk(3'd3, 0, 0, 0, 1), 5, "R8 R10 isolate no grant");
      push(mk(3'd4, 0, 0, 0, 1), 1, "R8 release");
      push(mk(3'd4, 0, 1, 0, 1), 1, "R8 xcvr back");
      push(mk(3'd0, 1, 1, 0, 1), 1, "R8 idle");
      raise_req();
      cyc(5);
      dma_req = 1'b0;
      static_sel = 1'b1;
      cyc(15);
      static_sel = 1'b0;
      cyc(5);

      // R9 new request arriving while release completes
      exp_dyn_take(3);
      raise_req();
      cyc(20);
      exp_dyn_rel();
      exp_dyn_take(1);
      dma_req = 1'b0;
      cyc(1);
      dma_req = 1'b1;
      cyc(25);
      exp_dyn_rel();
      dma_req = 1'b0;
      cyc(12);

      check("R7 R9 scoreboard drained", q.size(), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule